// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs the external bus cycles of a small 8-bit core with a 16-bit address space. The core hands over a single request: an address, write data, a direction and a flag that selects I/O or memory space. The block then steps the external pins through a three-phase cycle. The high address byte sits on its own pins for the whole cycle. The low address byte and the data take turns on one shared byte lane, and a one-cycle latch strobe marks the moment the lane carries address.

A slow device stretches the cycle by holding the ready input low, which adds wait phases. At the end of a read, the byte on the shared lane is captured and returned to the core with a one-cycle done pulse. A write returns the same pulse with no data.

A second bus master can ask for the bus. The request is granted only between cycles. While the grant is in force, every pin the block drives has its output enable turned off.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: During reset and in the first cycle after it: no address strobe, both active-low strobes high, no grant, no done pulse, shared lane not driven, read data 0.
- R2: A request is accepted in the cycle where `req_valid` and `req_ready` are both high. The next cycle is T1. In T1 only, `bus_ale` is high, `bus_ad_out` carries address bits 7:0 with `bus_ad_oe` high, and `bus_ahi` carries address bits 15:8 until the next acceptance.
- R3: `bus_iom` equals the request's `req_io` (1 = I/O space, 0 = memory space) from T1 until the next acceptance.
- R4: In a read, `bus_rd_n` is 0 from T2 through T3 and high at all other times, `bus_wr_n` stays 1, and `bus_ad_oe` is 0 while `bus_rd_n` is 0.
- R5: In a write, `bus_wr_n` is 0 from T2 through T3, `bus_rd_n` stays 1, and `bus_ad_out` carries the write data with `bus_ad_oe` high.
- R6: Each cycle in T2 or a wait phase in which `bus_ready` is 0 adds one more wait phase, and the strobe stays low. T3 follows the first strobe cycle in which `bus_ready` is 1.
- R7: The byte on `bus_ad_in` during the T3 of a read appears on `rsp_rdata` in the next cycle. In that same cycle `rsp_done` is high for exactly one cycle, after both reads and writes.
- R8: When `hold_req` is high at a cycle boundary (idle or T3), `hold_ack` is 1 in the next cycle and every output enable is 0. `hold_ack` falls in the cycle after the one in which `hold_req` is seen low.
- R9: A hold is never granted inside a cycle. A hold raised in T1, T2 or a wait phase is granted after T3. A hold takes priority over a request that is pending at the same boundary.
- R10: A request that is valid during T3 is accepted there, and its T1 follows with no idle cycle in between.
- R11: A write cycle leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core has a cycle to run |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last captured read byte |
| bus_ahi | output | 8 | High address byte |
| bus_ahi_oe | output | 1 | Enable for bus_ahi |
| bus_ad_out | output | 8 | Shared lane, outgoing value |
| bus_ad_oe | output | 1 | Enable for the shared lane |
| bus_ad_in | input | 8 | Shared lane, incoming value |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_iom | output | 1 | Space select, 1 = I/O |
| bus_ctl_oe | output | 1 | Enable for strobes and space select |
| bus_ready | input | 1 | Device ready, low adds wait phases |
| hold_req | input | 1 | Other master asks for the bus |
| hold_ack | output | 1 | Bus released |

## Verification
Every output of this block comes from its phase register. A wrong phase therefore shows at the pins in the same cycle: a missing or doubled latch strobe, a strobe that stays low one cycle too long, or a lane driven while the device drives it. A wrong latched request shows in the T1 address or in `bus_iom` no later than the cycle after acceptance. A mistake in capture shows on `rsp_rdata` one cycle after T3. The bench drives back-to-back cycles, long wait runs, and holds raised both between cycles and inside them, and it compares every pin against its model on every clock.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4,
        PH_HOLD = 3'd5
    } bus_phase_e;

    typedef struct packed {
        logic is_write;
        logic is_io;
    } cyc_kind_t;

    function automatic logic strobe_phase(input bus_phase_e ph);
        return (ph == PH_T2) || (ph == PH_TW) || (ph == PH_T3);
    endfunction

    function automatic logic boundary_phase(input bus_phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_T3);
    endfunction

endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       hold_req,
    input  logic       bus_ready,
    output bus_phase_e phase,
    output logic       accept
);
    bus_phase_e nxt;

    assign accept = boundary_phase(phase) && !hold_req && req_valid;

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE, PH_T3: begin
                if (hold_req)       nxt = PH_HOLD;
                else if (req_valid) nxt = PH_T1;
                else                nxt = PH_IDLE;
            end
            PH_T1:        nxt = PH_T2;
            PH_T2, PH_TW: nxt = bus_ready ? PH_T3 : PH_TW;
            PH_HOLD:      nxt = hold_req ? PH_HOLD : PH_IDLE;
            default:      nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/mbus_req_latch.sv
module mbus_req_latch
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  cyc_kind_t         in_kind,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output cyc_kind_t         cur_kind
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_kind  <= '0;
        end else if (accept) begin
            cur_addr  <= in_addr;
            cur_wdata <= in_wdata;
            cur_kind  <= in_kind;
        end
    end
endmodule

// File: rtl/mbus_pin_mux.sv
module mbus_pin_mux
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  bus_phase_e        phase,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    input  cyc_kind_t         cur_kind,
    output logic [HI_W-1:0]   pin_ahi,
    output logic              pin_ahi_oe,
    output logic [DATA_W-1:0] pin_ad,
    output logic              pin_ad_oe,
    output logic              pin_ale,
    output logic              pin_rd_n,
    output logic              pin_wr_n,
    output logic              pin_iom,
    output logic              pin_ctl_oe,
    output logic              pin_hlda
);
    logic strobing;
    logic owned;

    assign strobing = strobe_phase(phase);
    assign owned    = (phase != PH_HOLD);

    always_comb begin
        pin_ahi    = cur_addr[ADDR_W-1:DATA_W];
        pin_ahi_oe = owned;
        pin_ctl_oe = owned;
        pin_hlda   = !owned;
        pin_iom    = cur_kind.is_io;
        pin_ale    = (phase == PH_T1);
        pin_rd_n   = !(strobing && !cur_kind.is_write);
        pin_wr_n   = !(strobing && cur_kind.is_write);
        if (phase == PH_T1) begin
            pin_ad    = cur_addr[DATA_W-1:0];
            pin_ad_oe = 1'b1;
        end else begin
            pin_ad    = cur_wdata;
            pin_ad_oe = strobing && cur_kind.is_write;
        end
    end
endmodule

// File: rtl/mbus_rd_capture.sv
module mbus_rd_capture
    import mbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_phase_e        phase,
    input  cyc_kind_t         cur_kind,
    input  logic [DATA_W-1:0] lane_in,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= (phase == PH_T3);
            if (phase == PH_T3 && !cur_kind.is_write)
                rdata <= lane_in;
        end
    end
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [HI_W-1:0]   bus_ahi,
    output logic              bus_ahi_oe,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_iom,
    output logic              bus_ctl_oe,
    input  logic              bus_ready,
    input  logic              hold_req,
    output logic              hold_ack
);
    bus_phase_e        phase;
    logic              accept;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    cyc_kind_t         cur_kind;
    cyc_kind_t         in_kind;

    assign in_kind.is_write = req_write;
    assign in_kind.is_io    = req_io;
    assign req_ready        = accept;

    mbus_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .hold_req  (hold_req),
        .bus_ready (bus_ready),
        .phase     (phase),
        .accept    (accept)
    );

    mbus_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .in_kind   (in_kind),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_kind  (cur_kind)
    );

    mbus_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .phase      (phase),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .cur_kind   (cur_kind),
        .pin_ahi    (bus_ahi),
        .pin_ahi_oe (bus_ahi_oe),
        .pin_ad     (bus_ad_out),
        .pin_ad_oe  (bus_ad_oe),
        .pin_ale    (bus_ale),
        .pin_rd_n   (bus_rd_n),
        .pin_wr_n   (bus_wr_n),
        .pin_iom    (bus_iom),
        .pin_ctl_oe (bus_ctl_oe),
        .pin_hlda   (hold_ack)
    );

    mbus_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cur_kind (cur_kind),
        .lane_in  (bus_ad_in),
        .done     (rsp_done),
        .rdata    (rsp_rdata)
    );
endmodule

// File: rtl/mbus_cycle_ctrl_chk.sv
module mbus_cycle_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic bus_ale,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_ad_oe,
    input logic bus_ahi_oe,
    input logic bus_ctl_oe,
    input logic bus_iom,
    input logic bus_ready,
    input logic hold_req,
    input logic hold_ack,
    input logic rsp_done
);
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst) bus_ale |=> !bus_ale); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) bus_rd_n || bus_wr_n); // R4
    AST_READ_LANE_FREE: assert property (@(posedge clk) disable iff (rst) !bus_rd_n |-> !bus_ad_oe); // R4
    AST_SPACE_STEADY: assert property (@(posedge clk) disable iff (rst) (!bus_rd_n || !bus_wr_n) && !bus_ale && $past(!bus_rd_n || !bus_wr_n) |-> $stable(bus_iom)); // R3
    AST_WAIT_HOLDS_RD: assert property (@(posedge clk) disable iff (rst) (!bus_rd_n && !bus_ready) |=> !bus_rd_n); // R6
    AST_WAIT_HOLDS_WR: assert property (@(posedge clk) disable iff (rst) (!bus_wr_n && !bus_ready) |=> !bus_wr_n); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R7
    AST_HOLD_FLOATS: assert property (@(posedge clk) disable iff (rst) hold_ack |-> !bus_ad_oe && !bus_ahi_oe && !bus_ctl_oe); // R8
    AST_HOLD_DROP: assert property (@(posedge clk) disable iff (rst) (hold_ack && !hold_req) |=> !hold_ack); // R8
    AST_NO_GRANT_AFTER_ALE: assert property (@(posedge clk) disable iff (rst) bus_ale |=> !hold_ack); // R9
    AST_NO_GRANT_IN_WAIT: assert property (@(posedge clk) disable iff (rst) ((!bus_rd_n || !bus_wr_n) && !bus_ready) |=> !hold_ack); // R9
endmodule

bind mbus_cycle_ctrl mbus_cycle_ctrl_chk u_chk (.*);

// File: tb/mbus_cycle_ctrl_bench.sv
module mbus_cycle_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata, bus_ahi, bus_ad_out, bus_ad_in;
    logic        bus_ahi_oe, bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n, bus_iom, bus_ctl_oe;
    logic        bus_ready;
    logic        hold_req = 1'b0;
    logic        hold_ack;

    int total = 0;
    int bad = 0;
    bit cmp_en = 0;
    bit finished = 0;
    string scen = "R1";

    int          wait_left = 0;
    int          nxt_waits = 0;
    logic [15:0] lat_addr = '0;

    int          m_st = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic        m_wr = 1'b0;
    logic        m_io = 1'b0;
    logic        m_done = 1'b0;
    logic [7:0]  m_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_cycle_ctrl u_mbus_cycle_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .req_io(req_io), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_ahi(bus_ahi), .bus_ahi_oe(bus_ahi_oe),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_iom(bus_iom), .bus_ctl_oe(bus_ctl_oe), .bus_ready(bus_ready),
        .hold_req(hold_req), .hold_ack(hold_ack)
    );

    // device model: ready after a per-cycle wait count, data from latched address
    assign bus_ready = (wait_left == 0);
    assign bus_ad_in = lat_addr[15:8] ^ {lat_addr[3:0], lat_addr[7:4]} ^ 8'h3C;

    always @(posedge clk) begin
        if (bus_ale) lat_addr <= {bus_ahi, bus_ad_out};
        if (req_valid && req_ready) wait_left <= nxt_waits;
        else if ((!bus_rd_n || !bus_wr_n) && wait_left > 0) wait_left <= wait_left - 1;
        cmp_en <= 1'b1;
    end

    // reference model: 0 idle, 1 address phase, 2 strobe waiting, 3 last strobe, 4 bus released
    always @(posedge clk) begin
        if (rst) begin
            m_st <= 0; m_addr <= '0; m_wdata <= '0; m_wr <= 0; m_io <= 0;
            m_done <= 0; m_rdata <= '0;
        end else begin
            m_done <= (m_st == 3);
            if (m_st == 3 && !m_wr) m_rdata <= bus_ad_in;
            if (m_st == 0 || m_st == 3) begin
                if (hold_req) m_st <= 4;
                else if (req_valid) begin
                    m_st <= 1; m_addr <= req_addr; m_wdata <= req_wdata;
                    m_wr <= req_write; m_io <= req_io;
                end else m_st <= 0;
            end else if (m_st == 1) m_st <= 2;
            else if (m_st == 2) m_st <= bus_ready ? 3 : 2;
            else if (m_st == 4) m_st <= hold_req ? 4 : 0;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s:%s act=%h exp=%h t=%0t", scen, tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            automatic bit strb = (m_st == 2 || m_st == 3);
            automatic bit ad_en = (m_st == 1) || (strb && m_wr);
            chk("R2 ale", bus_ale, m_st == 1);
            chk("R2 ahi", bus_ahi, m_addr[15:8]);
            chk("R2/R5 ad_oe", bus_ad_oe, ad_en);
            if (ad_en) chk("R2/R5 ad_out", bus_ad_out, (m_st == 1) ? m_addr[7:0] : m_wdata);
            chk("R3 iom", bus_iom, m_io);
            chk("R4 rd_n", bus_rd_n, !(strb && !m_wr));
            chk("R5 wr_n", bus_wr_n, !(strb && m_wr));
            chk("R7 done", rsp_done, m_done);
            chk("R7/R11 rdata", rsp_rdata, m_rdata);
            chk("R8 hold_ack", hold_ack, m_st == 4);
            chk("R8 ctl_oe", bus_ctl_oe, m_st != 4);
            chk("R8 ahi_oe", bus_ahi_oe, m_st != 4);
            chk("R10 ready", req_ready, (m_st == 0 || m_st == 3) && !hold_req && req_valid);
        end
    end

    task automatic issue(input logic [15:0] a, input logic [7:0] d, input logic w,
                         input logic io, input int waits);
        req_addr = a; req_wdata = d; req_write = w; req_io = io; nxt_waits = waits;
        req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        scen = "R1";
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        settle(2);

        scen = "R4";
        issue(16'h12A5, 8'h00, 1'b0, 1'b0, 0); settle(6);
        scen = "R5";
        issue(16'hC034, 8'h9E, 1'b1, 1'b0, 0); settle(6);
        scen = "R6";
        issue(16'h00F7, 8'h00, 1'b0, 1'b1, 3); settle(9);
        issue(16'h4481, 8'h5B, 1'b1, 1'b1, 1); settle(7);
        scen = "R10";
        issue(16'h8001, 8'h00, 1'b0, 1'b0, 0);
        issue(16'h8002, 8'hA7, 1'b1, 1'b1, 2);
        issue(16'hFFFF, 8'h00, 1'b0, 1'b0, 0);
        settle(8);
        scen = "R11";
        issue(16'h0000, 8'h11, 1'b1, 1'b0, 0); settle(6);
        scen = "R8";
        hold_req = 1'b1; settle(4);
        hold_req = 1'b0; settle(3);
        scen = "R9";
        issue(16'h3C3C, 8'h00, 1'b0, 1'b1, 3);
        hold_req = 1'b1; settle(9);
        hold_req = 1'b0; settle(3);
        hold_req = 1'b1;
        fork
            begin settle(4); hold_req = 1'b0; end
        join_none
        issue(16'h7E10, 8'h00, 1'b0, 1'b0, 0);
        settle(8);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not complete act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule